// File: doc/BRIEF.md
# Per-Block Security Access Filter

This block sits on the path from one master to one memory port and decides, access by access, whether the request may go through. Memory is split into equal power-of-two blocks. Each block owns one bit in a lookup table held elsewhere. The filter reads that table through a combinational read port in the same cycle the request is presented. A block whose bit is 1 belongs to the non-secure world, and a block whose bit is 0 belongs to the secure world. Only a request from the owning world reaches memory.

A request from the wrong world never reaches memory. The filter answers it itself one cycle later: the read data is zero, and the response is a bus error or OKAY as the error-response control input selects. The first refused access is recorded in two fault registers, the address and a packed information word, and the filter asks the interrupt-status logic to set its status bit. Further refusals are logged only after software clears that status.

The downstream port must answer an accepted request in the cycle after acceptance, and in order. The interrupt-status bit and the lookup table sit outside the block.

Top module: `sec_block_filter`

## Requirements
- R1: The table read index equals the address shifted right by log2(block size)+5. The bit used within the returned 32-bit word is the address slice [log2(block size)+4 : log2(block size)]. The block size is a power of two of at least 32 bytes.
- R2: When the selected table bit is 1, only a non-secure request is forwarded. When the bit is 0, only a secure request is forwarded.
- R3: A request marked as having unknown attributes is treated as secure, whatever its non-secure input says.
- R4: A forwarded request appears on the downstream port with the same address, direction and write data, and `up_ready` follows `dn_ready`. The downstream response, error flag and read data are returned to the master.
- R5: A refused request is not forwarded and is accepted at once (`up_ready`=1). In the next cycle the filter returns a response with zero read data, and the error flag equals `err_resp_en` as sampled at acceptance.
- R6: When a refused request arrives while `irq_stat` is 0, `irq_set` is 1 in that cycle. From the next cycle `fault_addr` holds the full address, and `fault_info` holds the master ID in bits 15:0, the effective non-secure flag in bit 16, the selected table bit in bit 17, and zero above.
- R7: When a refused request arrives while `irq_stat` is 1, `irq_set` stays 0 and both fault registers keep their values. The request is still refused and answered locally.
- R8: After reset both fault registers read zero and no local response is pending.
- R9: With `up_req` low, neither `dn_req` nor `irq_set` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Master request valid (address phase) |
| up_addr | input | ADDR_W | Byte address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DATA_W | Write data |
| up_nonsec | input | 1 | 1 = non-secure request |
| up_attr_unknown | input | 1 | 1 = security attribute not given |
| up_master | input | 16 | Requesting master ID |
| up_ready | output | 1 | Request accepted this cycle |
| up_rsp_valid | output | 1 | Response to the master |
| up_rsp_err | output | 1 | 1 = bus error response |
| up_rdata | output | DATA_W | Read data to the master |
| dn_req | output | 1 | Forwarded request valid |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_ready | input | 1 | Memory accepts request |
| dn_rsp_valid | input | 1 | Memory response valid |
| dn_rsp_err | input | 1 | Memory error response |
| dn_rdata | input | DATA_W | Memory read data |
| lut_rd_idx | output | ADDR_W-log2(BLK_BYTES)-5 | Table word index |
| lut_rd_word | input | 32 | Table word at that index |
| err_resp_en | input | 1 | Refusals answer with bus error |
| irq_stat | input | 1 | Current interrupt status bit |
| irq_set | output | 1 | Request to set interrupt status |
| fault_addr | output | ADDR_W | Address of first refused access |
| fault_info | output | 32 | Master ID, non-secure flag, table bit of first refusal |

## Verification
The hardest case to reach is a second refusal that arrives while the status bit is still set from the first. It must leave the logged fault untouched and must not request a new interrupt, yet it still needs a local answer. The bench keeps its own status flip-flop, which `irq_set` sets and a bench pulse clears. The vector loop clears the status before each vector, and a directed pair of refusals with no clear between them produces the held-status case. Refusals while memory stalls, and unknown-attribute requests to non-secure blocks, cover the remaining corners.

// File: rtl/sec_filt_pkg.sv
// Package: shared types for the per-block security filter.
// Assumes a 16-bit master ID and a 32-bit fault information word.
package sec_filt_pkg;
    localparam int MID_W = 16;

    // Layout of the fault information word; upper bits are reserved zero.
    typedef struct packed {
        logic [13:0]      rsvd;
        logic             lut_bit;
        logic             nonsec;
        logic [MID_W-1:0] master;
    } fault_info_t;
endpackage

// File: rtl/sec_blk_decode.sv
// Block decode: splits an address into the table word index and the bit
// index, and picks the block's security bit from the returned table word.
// Assumes BLK_BYTES is a power of two of at least 32.
module sec_blk_decode #(
    parameter int ADDR_W    = 20,
    parameter int BLK_BYTES = 256
) (
    input  logic [ADDR_W-1:0]                         addr,
    input  logic [31:0]                               lut_word,
    output logic [ADDR_W-$clog2(BLK_BYTES)-6:0]       word_idx,
    output logic                                      blk_bit
);
    localparam int BLK_SH = $clog2(BLK_BYTES);
    localparam int WIDX_W = ADDR_W - BLK_SH - 5;

    logic [4:0] bit_idx;

    // Parameter sanity (R1): power-of-two block size, at least 32 bytes.
    initial begin
        a_r1_blk_size: assert (BLK_BYTES >= 32 && (1 << BLK_SH) == BLK_BYTES && WIDX_W >= 1)
            else $error("bad block size parameter");
    end

    // Address slicing and bit select (R1).
    always_comb begin
        word_idx = addr[ADDR_W-1 -: WIDX_W];
        bit_idx  = addr[BLK_SH+4:BLK_SH];
        blk_bit  = lut_word[bit_idx];
    end
endmodule

// File: rtl/sec_local_resp.sv
// Local responder: answers a refused access one cycle after acceptance with
// zero data and an error flag taken from the control input at acceptance.
// Assumes the downstream response never coincides with a local response.
module sec_local_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic err_en,
    output logic rsp_valid,
    output logic rsp_err
);
    // Register the local response for the data phase (R5, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_err   <= fire & err_en;
        end
    end
endmodule

// File: rtl/sec_fault_log.sv
// Fault log: holds the address and information word of the first refused
// access; capture is requested only while interrupt status is clear.
// Assumes the status bit is set by the edge on which capture happens.
module sec_fault_log
    import sec_filt_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refuse,
    input  logic              irq_stat,
    input  logic [ADDR_W-1:0] addr,
    input  fault_info_t       info_in,
    output logic              set_req,
    output logic [ADDR_W-1:0] fault_addr,
    output fault_info_t       fault_info
);
    // Capture only the first refusal (R6, R7).
    assign set_req = refuse & ~irq_stat;

    // Fault registers, cleared by reset (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
            fault_info <= '0;
        end else if (set_req) begin
            fault_addr <= addr;
            fault_info <= info_in;
        end
    end

    // R7: while status is set the log does not move.
    a_r7_log_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |=> ($stable(fault_addr) && $stable(fault_info)));
endmodule

// File: rtl/sec_block_filter.sv
// Per-block security filter: forwards requests whose security world matches
// the addressed block's table bit, answers the rest locally and logs the
// first refusal. Assumes downstream answers in the cycle after acceptance.
module sec_block_filter
    import sec_filt_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int BLK_BYTES = 256
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                up_req,
    input  logic [ADDR_W-1:0]                   up_addr,
    input  logic                                up_write,
    input  logic [DATA_W-1:0]                   up_wdata,
    input  logic                                up_nonsec,
    input  logic                                up_attr_unknown,
    input  logic [15:0]                         up_master,
    output logic                                up_ready,
    output logic                                up_rsp_valid,
    output logic                                up_rsp_err,
    output logic [DATA_W-1:0]                   up_rdata,
    output logic                                dn_req,
    output logic [ADDR_W-1:0]                   dn_addr,
    output logic                                dn_write,
    output logic [DATA_W-1:0]                   dn_wdata,
    input  logic                                dn_ready,
    input  logic                                dn_rsp_valid,
    input  logic                                dn_rsp_err,
    input  logic [DATA_W-1:0]                   dn_rdata,
    output logic [ADDR_W-$clog2(BLK_BYTES)-6:0] lut_rd_idx,
    input  logic [31:0]                         lut_rd_word,
    input  logic                                err_resp_en,
    input  logic                                irq_stat,
    output logic                                irq_set,
    output logic [ADDR_W-1:0]                   fault_addr,
    output logic [31:0]                         fault_info
);
    logic        blk_bit;
    logic        eff_ns;
    logic        pass;
    logic        refuse;
    logic        loc_valid;
    logic        loc_err;
    fault_info_t info_now;
    fault_info_t info_q;

    // Table lookup for the current address (R1).
    sec_blk_decode #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_dec (
        .addr     (up_addr),
        .lut_word (lut_rd_word),
        .word_idx (lut_rd_idx),
        .blk_bit  (blk_bit)
    );

    // World judgement: unknown attributes count as secure (R2, R3).
    always_comb begin
        eff_ns = up_nonsec & ~up_attr_unknown;
        pass   = (blk_bit == eff_ns);
        refuse = up_req & ~pass;
    end

    // Forwarding path and acceptance (R4, R5, R9).
    always_comb begin
        dn_req   = up_req & pass;
        dn_addr  = up_addr;
        dn_write = up_write;
        dn_wdata = up_wdata;
        up_ready = pass ? dn_ready : 1'b1;
    end

    // Fault information word assembled from the request (R6).
    always_comb begin
        info_now         = '0;
        info_now.master  = up_master;
        info_now.nonsec  = eff_ns;
        info_now.lut_bit = blk_bit;
    end

    sec_local_resp u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (refuse),
        .err_en    (err_resp_en),
        .rsp_valid (loc_valid),
        .rsp_err   (loc_err)
    );

    sec_fault_log #(.ADDR_W(ADDR_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .refuse     (refuse),
        .irq_stat   (irq_stat),
        .addr       (up_addr),
        .info_in    (info_now),
        .set_req    (irq_set),
        .fault_addr (fault_addr),
        .fault_info (info_q)
    );

    assign fault_info = info_q;

    // Response mux: local answer has zero data (R4, R5).
    always_comb begin
        up_rsp_valid = loc_valid | dn_rsp_valid;
        up_rsp_err   = loc_valid ? loc_err : dn_rsp_err;
        up_rdata     = loc_valid ? '0 : dn_rdata;
    end

    // R5: a request that is not forwarded is answered locally next cycle.
    a_r5_local_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !dn_req) |=> (up_rsp_valid && up_rdata == '0));

    // R5: a refused request never stalls the master.
    a_r5_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !dn_req) |-> up_ready);

    // R6: a set request leaves the address in the log.
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> (fault_addr == $past(up_addr)));

    // R9: idle master causes neither traffic nor interrupt.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !up_req |-> (!dn_req && !irq_set));

    // R7: no set request while status already set.
    a_r7_no_reset_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |-> !irq_set);
endmodule

// File: tb/sim_sec_block_filter.sv
module sim_sec_block_filter;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int BLK_BYTES = 256;
    localparam int WIDX_W = 7;
    localparam int NVEC = 11;

    // Vector: {addr[20], nonsec, unknown, write, errctl, exp_pass, master[16]}
    localparam logic [40:0] VEC [NVEC] = '{
        {20'h00010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011},
        {20'h00010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0022},
        {20'h00450, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0033},
        {20'h00450, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hBEEF},
        {20'h00700, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0044},
        {20'h02000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0055},
        {20'h03F00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0066},
        {20'h03E00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0077},
        {20'h00800, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0088},
        {20'hFFFF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0099},
        {20'h00100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h00AA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0, up_write = 1'b0, up_nonsec = 1'b0, up_attr_unknown = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [DATA_W-1:0] up_wdata = '0;
    logic [15:0] up_master = '0;
    logic up_ready, up_rsp_valid, up_rsp_err;
    logic [DATA_W-1:0] up_rdata;
    logic dn_req, dn_write;
    logic [ADDR_W-1:0] dn_addr;
    logic [DATA_W-1:0] dn_wdata;
    logic dn_ready = 1'b1;
    logic dn_rsp_valid, dn_rsp_err;
    logic [DATA_W-1:0] dn_rdata;
    logic dn_err_sel = 1'b0;
    logic [WIDX_W-1:0] lut_rd_idx;
    logic [31:0] lut_rd_word;
    logic err_resp_en = 1'b0;
    logic irq_stat, irq_set, stat_clr = 1'b0;
    logic [ADDR_W-1:0] fault_addr;
    logic [31:0] fault_info;
    logic [31:0] lut_mem [128];
    logic [ADDR_W-1:0] exp_faddr = '0;
    logic [31:0] exp_finfo = '0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sec_block_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_addr(up_addr), .up_write(up_write),
        .up_wdata(up_wdata), .up_nonsec(up_nonsec), .up_attr_unknown(up_attr_unknown),
        .up_master(up_master), .up_ready(up_ready), .up_rsp_valid(up_rsp_valid),
        .up_rsp_err(up_rsp_err), .up_rdata(up_rdata), .dn_req(dn_req), .dn_addr(dn_addr),
        .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_ready(dn_ready),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rdata(dn_rdata),
        .lut_rd_idx(lut_rd_idx), .lut_rd_word(lut_rd_word), .err_resp_en(err_resp_en),
        .irq_stat(irq_stat), .irq_set(irq_set), .fault_addr(fault_addr), .fault_info(fault_info)
    );

    assign lut_rd_word = lut_mem[lut_rd_idx];

    // Memory model: answers one cycle after acceptance.
    always @(posedge clk) begin
        dn_rsp_valid <= rst_n && dn_req && dn_ready;
        dn_rdata     <= {12'h5A5, dn_addr};
        dn_rsp_err   <= dn_err_sel;
    end

    // Interrupt status model.
    always @(posedge clk) begin
        if (!rst_n || stat_clr) irq_stat <= 1'b0;
        else if (irq_set) irq_stat <= 1'b1;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_stat();
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
    endtask

    task automatic do_access(input logic [ADDR_W-1:0] a, input logic ns, input logic unk,
                             input logic wr, input logic errc, input logic exp_pass,
                             input logic [15:0] mid);
        logic eff_ns, lbit, exp_irq, exp_vld, exp_err;
        @(negedge clk);
        up_req = 1'b1; up_addr = a; up_nonsec = ns; up_attr_unknown = unk;
        up_write = wr; up_master = mid; up_wdata = ~{12'h0, a}; err_resp_en = errc;
        eff_ns = ns & ~unk;
        lbit = lut_mem[a >> 13][a[12:8]];
        exp_irq = !exp_pass && !irq_stat;
        #1;
        chk(lut_rd_idx == a[19:13], "R1 table index", {25'b0, lut_rd_idx}, {25'b0, a[19:13]});
        chk((lbit == eff_ns) == exp_pass, "R2/R3 reference rule", {31'b0, lbit}, {31'b0, eff_ns});
        chk(dn_req == exp_pass, "R2 forward decision", {31'b0, dn_req}, {31'b0, exp_pass});
        chk(up_ready == (exp_pass ? dn_ready : 1'b1), "R5 ready", {31'b0, up_ready}, 32'b0);
        chk(irq_set == exp_irq, "R6 R7 irq_set", {31'b0, irq_set}, {31'b0, exp_irq});
        if (exp_pass)
            chk(dn_addr == a && dn_write == wr && dn_wdata == ~{12'h0, a}, "R4 forwarded fields",
                {12'b0, dn_addr}, {12'b0, a});
        exp_vld = exp_pass ? dn_ready : 1'b1;
        exp_err = exp_pass ? dn_err_sel : errc;
        if (exp_irq) begin
            exp_faddr = a;
            exp_finfo = {14'b0, lbit, eff_ns, mid};
        end
        @(negedge clk);
        up_req = 1'b0;
        #1;
        chk(up_rsp_valid == exp_vld, "R4 R5 response valid", {31'b0, up_rsp_valid}, {31'b0, exp_vld});
        if (exp_vld) begin
            chk(up_rsp_err == exp_err, "R4 R5 response error", {31'b0, up_rsp_err}, {31'b0, exp_err});
            chk(up_rdata == (exp_pass ? {12'h5A5, a} : 32'h0), "R4 R5 read data", up_rdata,
                exp_pass ? {12'h5A5, a} : 32'h0);
        end
        chk(fault_addr == exp_faddr, "R6 R7 fault address", {12'b0, fault_addr}, {12'b0, exp_faddr});
        chk(fault_info == exp_finfo, "R6 R7 fault info", fault_info, exp_finfo);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) lut_mem[i] = 32'h0;
        lut_mem[0] = 32'h0000_00F0;
        lut_mem[1] = 32'h8000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state.
        chk(fault_addr == '0, "R8 fault address after reset", {12'b0, fault_addr}, 32'h0);
        chk(fault_info == '0, "R8 fault info after reset", fault_info, 32'h0);
        chk(up_rsp_valid == 1'b0, "R8 no pending response", {31'b0, up_rsp_valid}, 32'h0);
        // R9: idle.
        chk(!dn_req && !irq_set, "R9 idle", {30'b0, dn_req, irq_set}, 32'h0);

        // Vector table walk, status cleared before each.
        for (int i = 0; i < NVEC; i++) begin
            clear_stat();
            do_access(VEC[i][40:21], VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17],
                      VEC[i][16], VEC[i][15:0]);
        end

        // R7: two refusals with status left set after the first.
        clear_stat();
        do_access(20'h00010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
        do_access(20'h00500, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h5678);

        // R4: downstream stall holds a passing request, refusal still accepted.
        dn_ready = 1'b0;
        do_access(20'h00020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0101);
        clear_stat();
        do_access(20'h00020, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0202);
        dn_ready = 1'b1;

        // R4: downstream error passed back to the master.
        dn_err_sel = 1'b1;
        do_access(20'h00400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0303);
        dn_err_sel = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule